// File: doc/BRIEF.md
# Device Protection Mode Controller

This block decides whether debug-port access, external full-erase requests and row reads or writes are allowed. It holds a device protection level in a register that stands in for non-volatile latches and is loaded with a fixed value at power-on. It answers each mode-change and erase request with a one-cycle accept or reject pulse. Flash programming, the debug protocol and erase timing are handled by other blocks. This block only grants or refuses requests and drives the matching enables.

There are three levels: unlocked, locked and a permanent lockout. The unlocked level is the default for a blank part. Leaving the locked level needs a finished full erase. The permanent lockout can never be left, and it refuses erase requests from outside. Per-row read and write guard bits hold back external row accesses. Requests that internal code makes through system calls always get through. Firmware can also turn off debug access. Only a completed full erase clears that flag.

Top module: `prot_mode_ctrl`

## Requirements
- R1: After reset the level is unlocked (`mode_o` = 2'b00), `dbg_en_o` and `ext_erase_en_o` are 1, no ack or nack is raised, no erase is busy and every row is readable and writable.
- R2: The level encoding is 2'b00 unlocked, 2'b01 locked, 2'b11 permanent lockout. A stored or requested 2'b10 acts as 2'b11, and `mode_o` then reports 2'b11.
- R3: A one-cycle `mode_req_i` gets exactly one of `mode_ack_o` or `mode_nack_o`, one cycle wide, after the next clock edge. `mode_o` changes only on that edge, and only together with an ack.
- R4: From unlocked, a request for locked or for permanent lockout is acked. Any request for the current level, and locked to lockout, is nacked.
- R5: Locked to unlocked is acked only if an erase has completed since the last entry into locked. Otherwise it is nacked.
- R6: In permanent lockout every mode request is nacked and `mode_o` stays 2'b11.
- R7: `dbg_en_o` is 1 only while the level is unlocked and the firmware debug-disable flag is clear.
- R8: A `fw_dbg_dis_i` pulse sets the debug-disable flag. It stays set until an erase completes.
- R9: In permanent lockout `ext_erase_en_o` is 0 and an external erase request (`erase_int_i` = 0) is nacked. An internal one (`erase_int_i` = 1) is still acked.
- R10: An erase request gets ack or nack after the next edge. An accepted erase holds `erase_busy_o` at 1 until `erase_done_i`. A request while busy is nacked. `erase_done_i` while not busy has no effect.
- R11: Row guard bits, written through `row_cfg_*` at index `row_cfg_idx_i`, block external reads (`row_cfg_rd_i` = 1) and writes (`row_cfg_wr_i` = 1) of that row on their own. With `acc_int_i` = 1, read and write are always enabled.
- R12: Erase completion clears all row guard bits and the debug-disable flag in the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on load) |
| mode_req_i | input | 1 | Mode-change request strobe |
| mode_tgt_i | input | 2 | Requested level |
| mode_ack_o | output | 1 | Mode request accepted |
| mode_nack_o | output | 1 | Mode request refused |
| mode_o | output | 2 | Current level, normalised |
| erase_req_i | input | 1 | Full-erase request strobe |
| erase_int_i | input | 1 | Erase comes from internal code |
| erase_done_i | input | 1 | Erase engine finished |
| erase_ack_o | output | 1 | Erase accepted |
| erase_nack_o | output | 1 | Erase refused |
| erase_busy_o | output | 1 | Accepted erase in progress |
| ext_erase_en_o | output | 1 | External erase permitted |
| fw_dbg_dis_i | input | 1 | Firmware debug-disable strobe |
| dbg_en_o | output | 1 | Debug access permitted |
| row_cfg_we_i | input | 1 | Row guard write strobe |
| row_cfg_idx_i | input | ROW_W | Row guard index |
| row_cfg_rd_i | input | 1 | Read guard value |
| row_cfg_wr_i | input | 1 | Write guard value |
| acc_idx_i | input | ROW_W | Row being accessed |
| acc_int_i | input | 1 | Access comes from internal code |
| row_rd_en_o | output | 1 | Read of accessed row permitted |
| row_wr_en_o | output | 1 | Write of accessed row permitted |

## Verification
The assertions assume that each request strobe stays high for one cycle. They also assume that `erase_done_i` is meant to finish an erase that this block accepted. A done pulse with nothing busy is still tolerated and has no effect. The bench drives every strobe for exactly one clock from a task on the falling edge. It also raises a stray done pulse on purpose, to show that such a pulse does not disturb the state.

// File: rtl/prot_pkg.sv
`timescale 1ns/1ps
package prot_pkg;
  typedef enum logic [1:0] {
    LVL_OPEN = 2'b00,
    LVL_LOCK = 2'b01,
    LVL_BAD  = 2'b10,
    LVL_KILL = 2'b11
  } lvl_e;

  // bit 1 set means lockout; corrupted 2'b10 fails safe
  function automatic lvl_e norm_lvl(input logic [1:0] raw);
    return raw[1] ? LVL_KILL : (raw[0] ? LVL_LOCK : LVL_OPEN);
  endfunction
endpackage

// File: rtl/prot_mode_fsm.sv
`timescale 1ns/1ps
module prot_mode_fsm
  import prot_pkg::*;
#(
  parameter logic [1:0] INIT_MODE = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] tgt_i,
  input  logic       erase_fin_i,
  output lvl_e       lvl_o,
  output logic       ack_o,
  output logic       nack_o,
  output logic       erased_o
);
  logic [1:0] lvl_q;
  logic       ack_q, nack_q, erased_q;
  lvl_e       cur, tgt;
  logic       legal;

  assign cur = norm_lvl(lvl_q);
  assign tgt = norm_lvl(tgt_i);

  always_comb begin
    legal = 1'b0;
    unique case (cur)
      LVL_OPEN: legal = (tgt == LVL_LOCK) || (tgt == LVL_KILL);
      LVL_LOCK: legal = (tgt == LVL_OPEN) && erased_q;
      default:  legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= INIT_MODE;
      ack_q    <= 1'b0;
      nack_q   <= 1'b0;
      erased_q <= 1'b0;
    end else begin
      ack_q  <= req_i && legal;
      nack_q <= req_i && !legal;
      if (req_i && legal) lvl_q <= tgt;
      // entering a protected level forgets any earlier erase
      if (req_i && legal && (tgt != LVL_OPEN)) erased_q <= 1'b0;
      else if (erase_fin_i)                   erased_q <= 1'b1;
    end
  end

  assign lvl_o    = cur;
  assign ack_o    = ack_q;
  assign nack_o   = nack_q;
  assign erased_o = erased_q;
endmodule

// File: rtl/prot_erase_ctrl.sv
`timescale 1ns/1ps
module prot_erase_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic int_i,
  input  logic kill_i,
  input  logic done_i,
  output logic ack_o,
  output logic nack_o,
  output logic busy_o,
  output logic fin_o,
  output logic ext_en_o
);
  logic busy_q, ack_q, nack_q, accept;

  assign ext_en_o = !kill_i;
  assign accept   = req_i && !busy_q && (int_i || ext_en_o);
  assign fin_o    = done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      ack_q  <= accept;
      nack_q <= req_i && !accept;
      if (accept)     busy_q <= 1'b1;
      else if (fin_o) busy_q <= 1'b0;
    end
  end

  assign ack_o  = ack_q;
  assign nack_o = nack_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/prot_row_guard.sv
`timescale 1ns/1ps
module prot_row_guard #(
  parameter int NUM_ROWS = 16,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] idx_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] acc_idx_i,
  input  logic             acc_int_i,
  output logic             rd_en_o,
  output logic             wr_en_o
);
  logic [NUM_ROWS-1:0] rd_blk_q, wr_blk_q;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic hit;
    assign hit = we_i && (idx_i == ROW_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_blk_q[r] <= 1'b0;
        wr_blk_q[r] <= 1'b0;
      end else if (clr_i) begin
        rd_blk_q[r] <= 1'b0;
        wr_blk_q[r] <= 1'b0;
      end else if (hit) begin
        rd_blk_q[r] <= rd_i;
        wr_blk_q[r] <= wr_i;
      end
    end
  end

  assign rd_en_o = acc_int_i || !rd_blk_q[acc_idx_i];
  assign wr_en_o = acc_int_i || !wr_blk_q[acc_idx_i];
endmodule

// File: rtl/prot_dbg_gate.sv
`timescale 1ns/1ps
module prot_dbg_gate
  import prot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e lvl_i,
  input  logic dis_i,
  input  logic clr_i,
  output logic en_o
);
  logic dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dis_q <= 1'b0;
    else if (clr_i) dis_q <= 1'b0;  // erase wins over a same-cycle disable
    else if (dis_i) dis_q <= 1'b1;
  end

  assign en_o = (lvl_i == LVL_OPEN) && !dis_q;
endmodule

// File: rtl/prot_mode_ctrl.sv
`timescale 1ns/1ps
module prot_mode_ctrl
  import prot_pkg::*;
#(
  parameter logic [1:0] INIT_MODE = 2'b00,
  parameter int NUM_ROWS = 16,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_req_i,
  input  logic [1:0]       mode_tgt_i,
  output logic             mode_ack_o,
  output logic             mode_nack_o,
  output logic [1:0]       mode_o,
  input  logic             erase_req_i,
  input  logic             erase_int_i,
  input  logic             erase_done_i,
  output logic             erase_ack_o,
  output logic             erase_nack_o,
  output logic             erase_busy_o,
  output logic             ext_erase_en_o,
  input  logic             fw_dbg_dis_i,
  output logic             dbg_en_o,
  input  logic             row_cfg_we_i,
  input  logic [ROW_W-1:0] row_cfg_idx_i,
  input  logic             row_cfg_rd_i,
  input  logic             row_cfg_wr_i,
  input  logic [ROW_W-1:0] acc_idx_i,
  input  logic             acc_int_i,
  output logic             row_rd_en_o,
  output logic             row_wr_en_o
);
  lvl_e lvl;
  logic erase_fin, erased;

  prot_mode_fsm #(.INIT_MODE(INIT_MODE)) u_fsm (
    .clk_i, .rst_ni,
    .req_i      (mode_req_i),
    .tgt_i      (mode_tgt_i),
    .erase_fin_i(erase_fin),
    .lvl_o      (lvl),
    .ack_o      (mode_ack_o),
    .nack_o     (mode_nack_o),
    .erased_o   (erased)
  );

  prot_erase_ctrl u_erase (
    .clk_i, .rst_ni,
    .req_i   (erase_req_i),
    .int_i   (erase_int_i),
    .kill_i  (lvl == LVL_KILL),
    .done_i  (erase_done_i),
    .ack_o   (erase_ack_o),
    .nack_o  (erase_nack_o),
    .busy_o  (erase_busy_o),
    .fin_o   (erase_fin),
    .ext_en_o(ext_erase_en_o)
  );

  prot_row_guard #(.NUM_ROWS(NUM_ROWS)) u_rows (
    .clk_i, .rst_ni,
    .clr_i    (erase_fin),
    .we_i     (row_cfg_we_i),
    .idx_i    (row_cfg_idx_i),
    .rd_i     (row_cfg_rd_i),
    .wr_i     (row_cfg_wr_i),
    .acc_idx_i(acc_idx_i),
    .acc_int_i(acc_int_i),
    .rd_en_o  (row_rd_en_o),
    .wr_en_o  (row_wr_en_o)
  );

  prot_dbg_gate u_dbg (
    .clk_i, .rst_ni,
    .lvl_i(lvl),
    .dis_i(fw_dbg_dis_i),
    .clr_i(erase_fin),
    .en_o (dbg_en_o)
  );

  assign mode_o = lvl;
endmodule

// File: rtl/prot_mode_ctrl_chk.sv
`timescale 1ns/1ps
module prot_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_req_i,
  input logic       mode_ack_o,
  input logic       mode_nack_o,
  input logic [1:0] mode_o,
  input logic       erased,
  input logic       erase_req_i,
  input logic       erase_int_i,
  input logic       erase_ack_o,
  input logic       erase_nack_o,
  input logic       erase_busy_o,
  input logic       ext_erase_en_o,
  input logic       dbg_en_o,
  input logic       acc_int_i,
  input logic       row_rd_en_o,
  input logic       row_wr_en_o
);
  p_one_answer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_i |=> (mode_ack_o ^ mode_nack_o));
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_req_i |=> !(mode_ack_o || mode_nack_o));
  p_move_on_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> mode_ack_o);
  p_unlock_needs_erase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'b01 && mode_o == 2'b00) |-> $past(erased));
  p_kill_trap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'b11) |-> (mode_o == 2'b11));
  p_dbg_only_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_en_o |-> (mode_o == 2'b00));
  p_kill_no_ext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> !ext_erase_en_o);
  p_kill_ext_nack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_i && !erase_int_i && mode_o == 2'b11) |=> erase_nack_o);
  p_erase_answer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_i |=> (erase_ack_o ^ erase_nack_o));
  p_busy_nack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_i && erase_busy_o) |=> erase_nack_o);
  p_internal_bypass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_int_i |-> (row_rd_en_o && row_wr_en_o));
endmodule

bind prot_mode_ctrl prot_mode_ctrl_chk u_chk (
  .clk_i, .rst_ni, .mode_req_i, .mode_ack_o, .mode_nack_o, .mode_o,
  .erased, .erase_req_i, .erase_int_i, .erase_ack_o, .erase_nack_o,
  .erase_busy_o, .ext_erase_en_o, .dbg_en_o, .acc_int_i,
  .row_rd_en_o, .row_wr_en_o
);

// File: tb/prot_mode_ctrl_test.sv
`timescale 1ns/1ps
module prot_mode_ctrl_test;
  localparam int NUM_ROWS = 16;
  localparam int ROW_W = $clog2(NUM_ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic mreq = 0, ereq = 0, eint = 0, edone = 0, fdis = 0;
  logic cwe = 0, crd = 0, cwr = 0, aint = 0;
  logic [1:0] mtgt = 0;
  logic [ROW_W-1:0] cidx = 0, aidx = 0;

  logic mack, mnack, eack, enack, ebusy, exten, dbgen, rden, wren;
  logic [1:0] mode;
  logic b_mack, b_mnack, b_eack, b_enack, b_ebusy, b_exten, b_dbgen, b_rden, b_wren;
  logic [1:0] b_mode;

  prot_mode_ctrl #(.NUM_ROWS(NUM_ROWS)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_req_i(mreq), .mode_tgt_i(mtgt), .mode_ack_o(mack), .mode_nack_o(mnack), .mode_o(mode),
    .erase_req_i(ereq), .erase_int_i(eint), .erase_done_i(edone),
    .erase_ack_o(eack), .erase_nack_o(enack), .erase_busy_o(ebusy), .ext_erase_en_o(exten),
    .fw_dbg_dis_i(fdis), .dbg_en_o(dbgen),
    .row_cfg_we_i(cwe), .row_cfg_idx_i(cidx), .row_cfg_rd_i(crd), .row_cfg_wr_i(cwr),
    .acc_idx_i(aidx), .acc_int_i(aint), .row_rd_en_o(rden), .row_wr_en_o(wren)
  );

  prot_mode_ctrl #(.INIT_MODE(2'b10), .NUM_ROWS(NUM_ROWS)) uut_bad (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_req_i(mreq), .mode_tgt_i(mtgt), .mode_ack_o(b_mack), .mode_nack_o(b_mnack), .mode_o(b_mode),
    .erase_req_i(ereq), .erase_int_i(eint), .erase_done_i(edone),
    .erase_ack_o(b_eack), .erase_nack_o(b_enack), .erase_busy_o(b_ebusy), .ext_erase_en_o(b_exten),
    .fw_dbg_dis_i(fdis), .dbg_en_o(b_dbgen),
    .row_cfg_we_i(cwe), .row_cfg_idx_i(cidx), .row_cfg_rd_i(crd), .row_cfg_wr_i(cwr),
    .acc_idx_i(aidx), .acc_int_i(aint), .row_rd_en_o(b_rden), .row_wr_en_o(b_wren)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one-cycle strobes driven on the falling edge; outputs settle after the rising edge
  task automatic do_mode(input logic [1:0] t);
    mreq = 1; mtgt = t;
    @(negedge clk);
    mreq = 0;
  endtask

  task automatic do_erase(input logic internal);
    ereq = 1; eint = internal;
    @(negedge clk);
    ereq = 0; eint = 0;
  endtask

  task automatic do_done();
    edone = 1;
    @(negedge clk);
    edone = 0;
  endtask

  task automatic do_row(input logic [ROW_W-1:0] i, input logic r, input logic w);
    cwe = 1; cidx = i; crd = r; cwr = w;
    @(negedge clk);
    cwe = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 mode", mode, 2'b00);
    chk("R1 dbg_en", dbgen, 1);
    chk("R1 ext_erase_en", exten, 1);
    chk("R1 ack/nack", {mack, mnack, eack, enack}, 0);
    chk("R1 busy", ebusy, 0);
    chk("R1 row enables", {rden, wren}, 2'b11);
    chk("R2 corrupt load reads as lockout", b_mode, 2'b11);
    chk("R2 corrupt load blocks debug/erase", {b_dbgen, b_exten}, 2'b00);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_lock();
    do_mode(2'b00);
    chk("R4 same-level nack", {mack, mnack}, 2'b01);
    chk("R3 mode held on nack", mode, 2'b00);
    do_mode(2'b01);
    chk("R4 lock ack", {mack, mnack}, 2'b10);
    chk("R3 mode updates with ack", mode, 2'b01);
    chk("R7 debug off when locked", dbgen, 0);
    @(negedge clk);
    chk("R3 ack one cycle", {mack, mnack}, 2'b00);
    do_mode(2'b11);
    chk("R4 lock to lockout nack", {mack, mnack}, 2'b01);
    do_mode(2'b00);
    chk("R5 unlock without erase nack", {mack, mnack, mode}, 4'b0101);
  endtask

  task automatic t_rows_and_unlock();
    do_row(3, 1, 0);
    do_row(5, 0, 1);
    aidx = 3; aint = 0; #1;
    chk("R11 row3 read blocked, write open", {rden, wren}, 2'b01);
    aidx = 5; #1;
    chk("R11 row5 write blocked, read open", {rden, wren}, 2'b10);
    aint = 1; #1;
    chk("R11 internal bypass", {rden, wren}, 2'b11);
    aint = 0; aidx = 3;
    do_erase(0);
    chk("R10 erase accepted when locked", {eack, enack, ebusy}, 3'b101);
    do_erase(0);
    chk("R10 erase while busy nack", {eack, enack, ebusy}, 3'b011);
    do_done();
    chk("R10 busy drops on done", ebusy, 0);
    chk("R12 row guards cleared", {rden, wren}, 2'b11);
    do_mode(2'b00);
    chk("R5 unlock after erase ack", {mack, mode}, 3'b100);
    chk("R7 debug back when unlocked", dbgen, 1);
    do_mode(2'b01);
    do_mode(2'b00);
    chk("R5 erase forgotten on relock", {mack, mnack, mode}, 4'b0101);
    do_erase(1);
    do_done();
    do_mode(2'b00);
    chk("R5 unlock after internal erase", mode, 2'b00);
  endtask

  task automatic t_fw_debug();
    fdis = 1; @(negedge clk); fdis = 0;
    chk("R8 firmware disable", dbgen, 0);
    repeat (3) @(negedge clk);
    chk("R8 disable sticky", dbgen, 0);
    do_done();
    chk("R10 stray done ignored", {dbgen, ebusy}, 2'b00);
    do_erase(0);
    chk("R8 still off while erasing", dbgen, 0);
    do_done();
    chk("R12 erase clears debug disable", dbgen, 1);
  endtask

  task automatic t_kill();
    do_mode(2'b11);
    chk("R4 lockout ack", {mack, mode}, 3'b111);
    chk("R9 ext erase disabled", exten, 0);
    chk("R7 debug off in lockout", dbgen, 0);
    do_mode(2'b00);
    chk("R6 unlock refused", {mack, mnack, mode}, 4'b0111);
    do_mode(2'b01);
    chk("R6 lock refused", {mack, mnack, mode}, 4'b0111);
    do_erase(0);
    chk("R9 external erase nack", {eack, enack, ebusy}, 3'b010);
    do_erase(1);
    chk("R9 internal erase ack", {eack, enack, ebusy}, 3'b101);
    do_done();
    do_mode(2'b00);
    chk("R6 erase cannot leave lockout", {mnack, mode}, 3'b111);
    chk("R2 corrupt instance still lockout", b_mode, 2'b11);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_lock();
    t_rows_and_unlock();
    t_fw_debug();
    t_kill();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule